// File: doc/BRIEF.md
# TDC Hit Buffer and Round-Robin Merger

This block gathers time-stamped edge events from eight TDC channels and merges them into one shared word buffer. Each channel offers at most one edge per clock, made up of a 3-bit fine time, a fine-time error flag, an edge polarity and a 22-bit coarse timestamp. An edge that is accepted is packed at once into a fixed 32-bit word and held in a two-entry staging buffer for its channel. A buffer of two entries is enough to hold both edges of a short pulse.

A round-robin arbiter moves at most one staged word per clock into a 1024-word main FIFO. The main FIFO is read through a show-ahead port. A per-channel disable mask throws hits away before they are stored. When a staging buffer has no room, the new edge is dropped and a sticky overflow bit is raised for that channel. When the main FIFO is full, the arbiter stops and every staging buffer keeps its words.

Top module: `tdc_hit_merger`

## Requirements
- R1: After reset the main FIFO is empty, `rd_data_o` is all zero, `fifo_full_o` is 0 and every `overflow_o` bit is 0.
- R2: Every stored word is packed as follows. Bit 31 is 1 (valid). Bit 30 is the polarity. Bits 29:26 are the channel index. Bits 25:4 are the coarse time. Bit 3 is the error flag. Bits 2:0 are the fine time.
- R3: Each channel stages up to 2 words. An edge is accepted when its buffer holds fewer than 2 words at that clock edge. This count is taken before any transfer out of the buffer in the same cycle.
- R4: An enabled edge that arrives while its buffer holds 2 words is dropped. It sets that channel's `overflow_o` bit, which stays set until reset.
- R5: An edge on a channel whose `ch_disable_i` bit is 1 is neither stored nor able to set that channel's overflow bit.
- R6: At most one word moves from the staging buffers into the main FIFO per clock. Channels are served round-robin: after channel c is served, the search starts at channel c+1 and wraps to 0. The first search after reset starts at channel 0.
- R7: An edge sampled at clock edge n can be read from `rd_data_o` after clock edge n+1, at the earliest.
- R8: The main FIFO holds 1024 words, and `fifo_full_o` is 1 when it holds 1024. While it is full, no transfer takes place and the staged words stay in their buffers. A slot freed by a read is filled no sooner than the following clock.
- R9: `rd_data_o` shows the oldest word in the FIFO and `rd_en_i` removes it. While the FIFO is empty, `rd_data_o` is zero, so bit 31 is clear, and `rd_en_i` has no effect.
- R10: A read and a transfer in the same clock are both carried out, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_valid_i | input | 8 | Edge present, one bit per channel |
| hit_fine_i | input | 24 | Fine time, 3 bits per channel |
| hit_err_i | input | 8 | Fine-time decode error per channel |
| hit_rise_i | input | 8 | Edge polarity per channel (1 = rising) |
| hit_coarse_i | input | 176 | Coarse time, 22 bits per channel |
| ch_disable_i | input | 8 | Drop hits on this channel when 1 |
| rd_en_i | input | 1 | Remove the word shown on rd_data_o |
| rd_data_o | output | 32 | Oldest FIFO word, zero when empty |
| fifo_empty_o | output | 1 | Main FIFO empty |
| fifo_full_o | output | 1 | Main FIFO holds 1024 words |
| overflow_o | output | 8 | Sticky staging overflow per channel |

## Verification
Two pairs of events can fall in the same clock. In the first, a channel takes in a new edge in the same cycle that its oldest word is moved out. In the second, the read port removes a word in the same cycle that the arbiter writes one, including at the full and empty boundaries. The bench provokes the first by firing all channels at once for several cycles, so that some buffers are refilled while they are being drained and others drop edges. It provokes the second by reading continuously while hits stream in, and by reading as a full FIFO is drained. A behavioural queue model, updated with the pre-edge state, judges every cycle.

// File: rtl/tdc_merge_pkg.sv
package tdc_merge_pkg;
  localparam int FINE_W   = 3;
  localparam int COARSE_W = 22;
  localparam int CHAN_W   = 4;
  localparam int WORD_W   = 32;

  typedef struct packed {
    logic                valid;
    logic                rise;
    logic [CHAN_W-1:0]   chan;
    logic [COARSE_W-1:0] coarse;
    logic                err;
    logic [FINE_W-1:0]   fine;
  } tdc_word_t;
endpackage

// File: rtl/tdc_ch_stage.sv
module tdc_ch_stage
  import tdc_merge_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hit_valid_i,
  input  logic      disable_i,
  input  tdc_word_t hit_word_i,
  input  logic      pop_i,
  output tdc_word_t word_o,
  output logic      nonempty_o,
  output logic      overflow_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  tdc_word_t        mem_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, push, drop, ovf_q;

  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign push       = hit_valid_i && !disable_i && !full;
  assign drop       = hit_valid_i && !disable_i && full;
  assign nonempty_o = (cnt_q != '0);
  assign word_o     = mem_q[rd_ptr_q];
  assign overflow_o = ovf_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (push) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i) rd_ptr_q <= nxt(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop_i);
      if (drop) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q] <= hit_word_i;
  end

  // R3
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> nonempty_o);
  // R4
  drop_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_i && !disable_i && full) |=> overflow_o);
  // R4
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  // R5
  masked_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_i && disable_i && !pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tdc_rr_arb.sv
module tdc_rr_arb #(
  parameter int N = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         req_i,
  input  logic                 stall_i,
  output logic [N-1:0]         grant_o,
  output logic [$clog2(N)-1:0] grant_idx_o,
  output logic                 grant_any_o
);
  localparam int IDX_W = $clog2(N);

  logic [IDX_W-1:0] last_q;
  logic             found;
  int               idx;

  always_comb begin
    found       = 1'b0;
    grant_idx_o = '0;
    idx         = 0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (!found && req_i[idx]) begin
        found       = 1'b1;
        grant_idx_o = IDX_W'(idx);
      end
    end
    grant_any_o = found && !stall_i;
    grant_o     = grant_any_o ? (N'(1) << grant_idx_o) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= IDX_W'(N - 1);
    else if (grant_any_o) last_q <= grant_idx_o;
  end

  // R6
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && ((grant_o & ~req_i) == '0));
  // R8
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> (grant_o == '0));
endmodule

// File: rtl/tdc_main_fifo.sv
module tdc_main_fifo #(
  parameter int DEPTH = 1024,
  parameter int W     = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [W-1:0]      mem_q [DEPTH];
  logic [ADDR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [ADDR_W:0]   cnt_q;
  logic              do_rd, do_wr;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (ADDR_W+1)'(DEPTH));
  assign do_rd   = rd_i && !empty_o;
  assign do_wr   = wr_i && !full_o;
  assign rdata_o = empty_o ? '0 : mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_rd) rd_ptr_q <= rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + (ADDR_W+1)'(do_wr) - (ADDR_W+1)'(do_rd);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wr_ptr_q] <= wdata_i;
  end

  // R8
  wr_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && full_o));
  // R9
  empty_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_o && !wr_i) |=> empty_o);
  // R10
  rd_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_rd && do_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/tdc_hit_merger.sv
module tdc_hit_merger
  import tdc_merge_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int STAGE_DEPTH = 2,
  parameter int FIFO_DEPTH = 1024,
  localparam int FW        = tdc_merge_pkg::FINE_W,
  localparam int CW        = tdc_merge_pkg::COARSE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH-1:0]    hit_valid_i,
  input  logic [NUM_CH*FW-1:0] hit_fine_i,
  input  logic [NUM_CH-1:0]    hit_err_i,
  input  logic [NUM_CH-1:0]    hit_rise_i,
  input  logic [NUM_CH*CW-1:0] hit_coarse_i,
  input  logic [NUM_CH-1:0]    ch_disable_i,
  input  logic                 rd_en_i,
  output logic [WORD_W-1:0]    rd_data_o,
  output logic                 fifo_empty_o,
  output logic                 fifo_full_o,
  output logic [NUM_CH-1:0]    overflow_o
);
  localparam int IDX_W = $clog2(NUM_CH);

  tdc_word_t         stage_word [NUM_CH];
  logic [NUM_CH-1:0] stage_req, grant;
  logic [IDX_W-1:0]  grant_idx;
  logic              grant_any;
  tdc_word_t         xfer_word;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tdc_word_t packed_hit;
    assign packed_hit = '{valid:  1'b1,
                          rise:   hit_rise_i[g],
                          chan:   CHAN_W'(g),
                          coarse: hit_coarse_i[g*CW +: CW],
                          err:    hit_err_i[g],
                          fine:   hit_fine_i[g*FW +: FW]};

    tdc_ch_stage #(.DEPTH(STAGE_DEPTH)) i_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hit_valid_i(hit_valid_i[g]),
      .disable_i  (ch_disable_i[g]),
      .hit_word_i (packed_hit),
      .pop_i      (grant[g]),
      .word_o     (stage_word[g]),
      .nonempty_o (stage_req[g]),
      .overflow_o (overflow_o[g])
    );
  end

  tdc_rr_arb #(.N(NUM_CH)) i_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (stage_req),
    .stall_i    (fifo_full_o),
    .grant_o    (grant),
    .grant_idx_o(grant_idx),
    .grant_any_o(grant_any)
  );

  assign xfer_word = stage_word[grant_idx];

  tdc_main_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) i_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (grant_any),
    .wdata_i(xfer_word),
    .rd_i   (rd_en_i),
    .rdata_o(rd_data_o),
    .empty_o(fifo_empty_o),
    .full_o (fifo_full_o)
  );

  // R2
  word_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_any |-> (xfer_word.valid && (xfer_word.chan == CHAN_W'(grant_idx))));
  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (fifo_empty_o && overflow_o == '0 && rd_data_o == '0));
endmodule

// File: tb/test_tdc_hit_merger.sv
`timescale 1ns/1ps
module test_tdc_hit_merger;
  localparam int NCH = 8;
  localparam int DEP = 1024;

  logic           clk_i = 0, rst_ni = 0;
  logic [7:0]     hv = 0, dis = 0, err = 0, rise = 0;
  logic [23:0]    fine = 0;
  logic [175:0]   coarse = 0;
  logic           rd_en = 0;
  logic [31:0]    rd_data;
  logic           f_empty, f_full;
  logic [7:0]     ovf;

  tdc_hit_merger i_tdc_hit_merger (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_valid_i(hv), .hit_fine_i(fine),
    .hit_err_i(err), .hit_rise_i(rise), .hit_coarse_i(coarse),
    .ch_disable_i(dis), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .fifo_empty_o(f_empty), .fifo_full_o(f_full), .overflow_o(ovf));

  always #2 clk_i = ~clk_i;

  int errs = 0, checks = 0;
  string cur_tag = "R1";
  logic [31:0] sq [NCH][$];
  logic [31:0] mq [$];
  logic [7:0]  m_ovf = 0;
  int          m_last = NCH - 1;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // reference model, pre-edge state decides everything
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++) sq[c].delete();
      mq.delete(); m_ovf = 0; m_last = NCH - 1;
    end else begin
      int pre [NCH];
      int g;
      g = -1;
      for (int c = 0; c < NCH; c++) pre[c] = sq[c].size();
      if (mq.size() < DEP)
        for (int k = 1; k <= NCH; k++)
          if (g < 0 && pre[(m_last + k) % NCH] > 0) g = (m_last + k) % NCH;
      if (rd_en && mq.size() > 0) void'(mq.pop_front());
      if (g >= 0) begin mq.push_back(sq[g].pop_front()); m_last = g; end
      for (int c = 0; c < NCH; c++)
        if (hv[c] && !dis[c]) begin
          if (pre[c] < 2)
            sq[c].push_back({1'b1, rise[c], 4'(c), coarse[c*22 +: 22], err[c], fine[c*3 +: 3]});
          else m_ovf[c] = 1'b1;
        end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic [31:0] e;
      e = (mq.size() > 0) ? mq[0] : 32'h0;
      chk(cur_tag, {21'h0, rd_data, f_empty, f_full, ovf},
                   {21'h0, e, mq.size() == 0, mq.size() == DEP, m_ovf});
    end
  end

  task automatic do_reset();
    @(negedge clk_i); #1 rst_ni = 0;
    hv = 0; rd_en = 0; dis = 0;
    repeat (2) @(negedge clk_i); #1 rst_ni = 1;
  endtask

  task automatic set_hit(input int c, input logic [2:0] f, input logic e,
                         input logic r, input logic [21:0] t);
    hv[c] = 1; fine[c*3 +: 3] = f; err[c] = e; rise[c] = r; coarse[c*22 +: 22] = t;
  endtask

  task automatic drain();
    rd_en = 1;
    for (int i = 0; i < 2000 && !f_empty; i++) @(negedge clk_i);
    rd_en = 0;
  endtask

  initial begin
    #(4.0 * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk("R1", {f_empty, f_full, ovf, rd_data}, {1'b1, 1'b0, 8'h0, 32'h0});
    #1 rst_ni = 1;

    // R2 / R7 single hit, layout
    cur_tag = "R2";
    @(negedge clk_i); set_hit(3, 3'd5, 1'b0, 1'b1, 22'h12345);
    @(negedge clk_i); hv = 0;
    chk("R7", {31'h0, f_empty}, 64'h1);
    @(negedge clk_i);
    chk("R2", {32'h0, rd_data}, {32'h0, 32'hCC123455});
    set_hit(6, 3'd2, 1'b1, 1'b0, 22'h3FFFFF);
    @(negedge clk_i); hv = 0; rd_en = 1;
    @(negedge clk_i); rd_en = 0;
    chk("R2", {32'h0, rd_data}, {32'h0, 32'h9BFFFFFA});
    drain();

    // R6 round robin from channel 0 after reset
    do_reset(); cur_tag = "R6";
    @(negedge clk_i);
    for (int c = 0; c < NCH; c++) set_hit(c, 3'(c), 1'b0, 1'b1, 22'(c * 7));
    @(negedge clk_i); hv = 0;
    repeat (9) @(negedge clk_i);
    rd_en = 1;
    for (int c = 0; c < NCH; c++) begin
      chk("R6", {60'h0, rd_data[29:26]}, 64'(c));
      @(negedge clk_i);
    end
    rd_en = 0;

    // R3 / R4 all channels for three cycles
    do_reset(); cur_tag = "R4";
    @(negedge clk_i);
    for (int c = 0; c < NCH; c++) set_hit(c, 3'd1, 1'b0, 1'b1, 22'd100);
    repeat (3) @(negedge clk_i);
    hv = 0;
    chk("R4", {56'h0, ovf}, 64'hFE);
    cur_tag = "R3";
    repeat (20) @(negedge clk_i);
    chk("R4", {56'h0, ovf}, 64'hFE);
    drain();

    // R5 disabled channel
    do_reset(); cur_tag = "R5";
    dis = 8'h04;
    @(negedge clk_i);
    for (int i = 0; i < 6; i++) begin set_hit(2, 3'd3, 1'b0, 1'b1, 22'(i)); @(negedge clk_i); end
    hv = 0;
    repeat (2) @(negedge clk_i);
    chk("R5", {55'h0, f_empty, ovf}, {55'h0, 1'b1, 8'h00});
    dis = 0;

    // R10 streaming with continuous read
    cur_tag = "R10"; rd_en = 1;
    for (int i = 0; i < 40; i++) begin
      hv = 0;
      if (i % 2 == 0) set_hit(1, 3'(i), 1'b0, i[1], 22'(i));
      if (i % 3 == 0) set_hit(4, 3'(i), 1'b1, 1'b1, 22'(i * 3));
      @(negedge clk_i);
    end
    hv = 0;
    repeat (6) @(negedge clk_i);
    rd_en = 0;

    // R9 read while empty
    cur_tag = "R9"; rd_en = 1;
    repeat (3) @(negedge clk_i);
    chk("R9", {31'h0, rd_data, f_empty}, {31'h0, 32'h0, 1'b1});
    rd_en = 0;

    // R8 fill to full, stall, drain
    do_reset(); cur_tag = "R8";
    for (int i = 0; i < 1100; i++) begin
      for (int c = 0; c < NCH; c++) set_hit(c, 3'(i), i[2], i[0], 22'(i * 8 + c));
      @(negedge clk_i);
    end
    hv = 0;
    chk("R8", {62'h0, f_full, f_empty}, 64'h2);
    chk("R8", {56'h0, ovf}, 64'hFF);
    repeat (5) @(negedge clk_i);
    chk("R8", {63'h0, f_full}, 64'h1);
    cur_tag = "R10";
    drain();
    chk("R9", {31'h0, rd_data, f_empty}, {31'h0, 32'h0, 1'b1});

    repeat (2) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule